// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

This block is the configurable logic core of a 22V10-class programmable device. Twelve dedicated inputs and ten feedback signals are each presented in true and in complement form, giving 44 input lines. 132 product terms are each a wide AND over whichever of those lines the configuration connects. Fixed OR gates then merge the product terms into ten sums. The remaining product terms come out directly as ten output-enable terms, a global preset term and a global clear term, which the output macrocells use.

The configuration is one bit per line/term crossing, 5808 bits in all. It is held in an on-block shift register and loaded serially, most significant bit first, while a shift-enable input is high. Evaluation is purely combinational from the stored bits. The product terms are not shared evenly. The two outer outputs get 8 terms each, and the count rises by two per output toward the middle, where the two centre outputs get 16 each.

Top module: `pla_sop_core`

## Requirements
- R1: Input line 2*s carries the true value and line 2*s+1 the complement of signal s, where signals 0..11 are `ded_in[0..11]` and signals 12..21 are `fb_in[0..9]`.
- R2: Configuration bit p*44+l controls line l of product term p, and a value of 1 connects the line while 0 leaves it open.
- R3: On every rising `clk` with `cfg_shift_en` high, `cfg_data` enters bit 0 and all stored bits move up one place, so after 5808 shifts the first bit sent occupies bit 5807.
- R4: With `cfg_shift_en` low, the stored configuration is unchanged whatever `cfg_data` does.
- R5: A synchronous active-high `rst` clears every configuration bit, so every product term and every output then reads 1.
- R6: A product term with no connected line evaluates to 1.
- R7: A product term connected to both forms of the same signal evaluates to 0.
- R8: In all other cases, a product term is the AND of its connected lines.
- R9: Terms 0..119 are sum terms, assigned in order from output 0 to output 9 in blocks of 8, 10, 12, 14, 16, 16, 14, 12, 10, 8. `sum_out[o]` is the OR of its block.
- R10: Term 120+o drives `oe_out[o]`, term 130 drives `preset_out`, and term 131 drives `clear_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst | input | 1 | Synchronous active-high reset of the configuration |
| cfg_shift_en | input | 1 | Shift one configuration bit per clock when high |
| cfg_data | input | 1 | Serial configuration bit |
| ded_in | input | 12 | Dedicated logic inputs |
| fb_in | input | 10 | Feedback signals from the I/O cells |
| sum_out | output | 10 | OR of each output's product-term block |
| oe_out | output | 10 | Output-enable product terms |
| preset_out | output | 1 | Global preset product term |
| clear_out | output | 1 | Global clear product term |

## Verification
Some properties are checked on every clock by assertions. These are: the stored configuration holds while shifting is idle, reset empties it, a term with an empty row reads true, a term that connects both forms of a signal reads false, and a sum cannot be high unless a term in its own block is high. Other behaviour shows only in the bench's scenarios, which load whole configurations serially and compare all 22 outputs against a model built from the requirements. These scenarios cover the MSB-first bit order, the line numbering of dedicated and feedback signals, and the exact block boundaries between outputs, which are tested by walking a single active input across each output's first and last term.

// File: rtl/pla_pkg.sv
package pla_pkg;

    localparam int N_DED      = 12;
    localparam int N_FB       = 10;
    localparam int N_SIG      = N_DED + N_FB;
    localparam int N_LINE     = 2 * N_SIG;
    localparam int N_OUT      = N_FB;
    localparam int CNT_MIN    = 8;
    localparam int CNT_STEP   = 2;
    localparam int N_SUM_PT   = 120;
    localparam int PT_OE_BASE = N_SUM_PT;
    localparam int PT_PRESET  = PT_OE_BASE + N_OUT;
    localparam int PT_CLEAR   = PT_PRESET + 1;
    localparam int N_PT       = PT_CLEAR + 1;
    localparam int CFG_W      = N_LINE * N_PT;

    typedef struct packed {
        logic [N_OUT-1:0] sum;
        logic [N_OUT-1:0] oe;
        logic             preset;
        logic             clear;
    } pla_result_t;

    // number of sum terms feeding output o: rises toward the middle
    function automatic int sum_cnt(input int o);
        if (o < N_OUT / 2)
            return CNT_MIN + CNT_STEP * o;
        else
            return CNT_MIN + CNT_STEP * (N_OUT - 1 - o);
    endfunction

    // index of the first sum term belonging to output o
    function automatic int sum_base(input int o);
        int b;
        b = 0;
        for (int k = 0; k < o; k++) b += sum_cnt(k);
        return b;
    endfunction

    // true if a row connects both the true and complement line of any signal
    function automatic logic row_has_pair(input logic [N_LINE-1:0] row);
        logic hit;
        hit = 1'b0;
        for (int s = 0; s < N_SIG; s++)
            if (row[2*s] && row[2*s+1]) hit = 1'b1;
        return hit;
    endfunction

endpackage

// File: rtl/pla_line_gen.sv
module pla_line_gen
    import pla_pkg::*;
(
    input  logic [N_DED-1:0]  ded_in,
    input  logic [N_FB-1:0]   fb_in,
    output logic [N_LINE-1:0] lines
);
    logic [N_SIG-1:0] sig;

    assign sig = {fb_in, ded_in};

    // R1: even line = true form, odd line = complement
    for (genvar s = 0; s < N_SIG; s++) begin : g_sig
        assign lines[2*s]   = sig[s];
        assign lines[2*s+1] = ~sig[s];
    end
endmodule

// File: rtl/pla_cfg_shift.sv
module pla_cfg_shift
    import pla_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic             sin,
    output logic [CFG_W-1:0] cfg_q
);
    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (shift_en)
            cfg_q <= {cfg_q[CFG_W-2:0], sin};
    end

    a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(cfg_q));

    a_r5_reset_clears: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cfg_q == '0));

    a_r3_msb_first_entry: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (cfg_q[0] == $past(sin)));
endmodule

// File: rtl/pla_pterm.sv
module pla_pterm
    import pla_pkg::*;
(
    input  logic [N_LINE-1:0] row,
    input  logic [N_LINE-1:0] lines,
    output logic              term
);
    // an open crossing passes 1 into the AND; a connected one passes the line
    assign term = &(~row | lines);
endmodule

// File: rtl/pla_sop_core.sv
module pla_sop_core
    import pla_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_shift_en,
    input  logic             cfg_data,
    input  logic [11:0]      ded_in,
    input  logic [9:0]       fb_in,
    output logic [9:0]       sum_out,
    output logic [9:0]       oe_out,
    output logic             preset_out,
    output logic             clear_out
);
    logic [N_LINE-1:0] lines;
    logic [CFG_W-1:0]  cfg;
    logic [N_PT-1:0]   pt;
    pla_result_t       res;

    pla_line_gen u_lines (
        .ded_in (ded_in),
        .fb_in  (fb_in),
        .lines  (lines)
    );

    pla_cfg_shift u_cfg (
        .clk      (clk),
        .rst      (rst),
        .shift_en (cfg_shift_en),
        .sin      (cfg_data),
        .cfg_q    (cfg)
    );

    for (genvar p = 0; p < N_PT; p++) begin : g_pt
        pla_pterm u_pt (
            .row   (cfg[p*N_LINE +: N_LINE]),
            .lines (lines),
            .term  (pt[p])
        );

        a_r6_open_term_true: assert property (@(posedge clk) disable iff (rst)
            (cfg[p*N_LINE +: N_LINE] == '0) |-> pt[p]);

        a_r7_both_forms_false: assert property (@(posedge clk) disable iff (rst)
            row_has_pair(cfg[p*N_LINE +: N_LINE]) |-> !pt[p]);
    end

    // R9: fixed OR over each output's uneven block of sum terms
    for (genvar o = 0; o < N_OUT; o++) begin : g_or
        localparam int BASE = sum_base(o);
        localparam int CNT  = sum_cnt(o);

        assign res.sum[o] = |pt[BASE +: CNT];

        a_r9_or_needs_term: assert property (@(posedge clk) disable iff (rst)
            sum_out[o] |-> (|pt[BASE +: CNT]));
    end

    // R10: dedicated terms after the sum blocks
    assign res.oe     = pt[PT_OE_BASE +: N_OUT];
    assign res.preset = pt[PT_PRESET];
    assign res.clear  = pt[PT_CLEAR];

    assign sum_out    = res.sum;
    assign oe_out     = res.oe;
    assign preset_out = res.preset;
    assign clear_out  = res.clear;
endmodule

// File: tb/pla_sop_core_bench.sv
module pla_sop_core_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NL  = 44;
    localparam int NP  = 132;
    localparam int CW  = NL * NP;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_shift_en = 1'b0;
    logic        cfg_data = 1'b0;
    logic [11:0] ded_in = '0;
    logic [9:0]  fb_in = '0;
    logic [9:0]  sum_out;
    logic [9:0]  oe_out;
    logic        preset_out;
    logic        clear_out;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [CW-1:0] tb_cfg;
    int cnt_tab[10] = '{8, 10, 12, 14, 16, 16, 14, 12, 10, 8};

    typedef struct {
        logic [21:0] exp;
        string       req;
    } item_t;
    item_t q[$];
    event  chk_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    pla_sop_core u_pla_sop_core (
        .clk          (clk),
        .rst          (rst),
        .cfg_shift_en (cfg_shift_en),
        .cfg_data     (cfg_data),
        .ded_in       (ded_in),
        .fb_in        (fb_in),
        .sum_out      (sum_out),
        .oe_out       (oe_out),
        .preset_out   (preset_out),
        .clear_out    (clear_out)
    );

    // reference model written from the requirements
    function automatic logic [21:0] model(input logic [CW-1:0] c,
                                          input logic [11:0] d,
                                          input logic [9:0] f);
        logic [NP-1:0] t;
        logic [9:0] s;
        int b;
        for (int p = 0; p < NP; p++) begin
            t[p] = 1'b1;
            for (int l = 0; l < NL; l++) begin
                int sg;
                logic v;
                sg = l / 2;
                v  = (sg < 12) ? d[sg] : f[sg-12];
                if (l % 2 == 1) v = ~v;
                if (c[p*NL + l] && !v) t[p] = 1'b0;
            end
        end
        b = 0;
        for (int o = 0; o < 10; o++) begin
            s[o] = 1'b0;
            for (int k = 0; k < cnt_tab[o]; k++) s[o] |= t[b+k];
            b += cnt_tab[o];
        end
        return {s, t[129:120], t[130], t[131]};
    endfunction

    function automatic int line_of(input int sg, input bit comp);
        return 2*sg + (comp ? 1 : 0);
    endfunction

    task automatic connect(input int p, input int l);
        tb_cfg[p*NL + l] = 1'b1;
    endtask

    task automatic clear_row(input int p);
        for (int l = 0; l < NL; l++) tb_cfg[p*NL + l] = 1'b0;
    endtask

    task automatic load_cfg();
        for (int i = CW-1; i >= 0; i--) begin
            @(negedge clk);
            cfg_shift_en = 1'b1;
            cfg_data     = tb_cfg[i];
        end
        @(negedge clk);
        cfg_shift_en = 1'b0;
    endtask

    // driver: apply inputs, push expected item
    task automatic drive(input logic [11:0] d, input logic [9:0] f, input string req);
        item_t it;
        @(negedge clk);
        ded_in = d;
        fb_in  = f;
        it.exp = model(tb_cfg, d, f);
        it.req = req;
        q.push_back(it);
        -> chk_ev;
    endtask

    // monitor: pop and compare
    initial begin
        forever begin
            @(chk_ev);
            #1;
            while (q.size() > 0) begin
                item_t it;
                logic [21:0] got;
                it  = q.pop_front();
                got = {sum_out, oe_out, preset_out, clear_out};
                tests++;
                if (got !== it.exp) begin
                    fails++;
                    $display("FAIL %s: got %h expected %h", it.req, got, it.exp);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        tb_cfg = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R5 and R6: empty configuration, all terms true
        drive(12'h000, 10'h000, "R5 reset state");
        drive(12'hABC, 10'h155, "R6 open terms");

        // configuration A: every term false by default (R7)
        tb_cfg = '0;
        for (int p = 0; p < NP; p++) begin
            connect(p, line_of(2, 1'b0));
            connect(p, line_of(2, 1'b1));
        end
        clear_row(0);   connect(0, line_of(0, 1'b0)); connect(0, line_of(1, 1'b1));
        clear_row(17);  connect(17, line_of(12, 1'b0));
        clear_row(18);
        clear_row(123); connect(123, line_of(5, 1'b1));
        clear_row(130); connect(130, line_of(21, 1'b0));
        clear_row(131);
        load_cfg();

        drive(12'h000, 10'h000, "R7 both forms false");
        drive(12'h001, 10'h000, "R8 AND true/complement");
        drive(12'h003, 10'h000, "R8 AND blocked by complement");
        drive(12'h004, 10'h000, "R7 pair ignores input");
        drive(12'h000, 10'h001, "R1 feedback line");
        drive(12'h020, 10'h200, "R10 oe and preset terms");
        drive(12'hFFF, 10'h3FF, "R2 R3 all ones");

        // configuration B: first and last slot of each block live (R9)
        tb_cfg = '0;
        for (int p = 0; p < NP; p++) begin
            connect(p, line_of(2, 1'b0));
            connect(p, line_of(2, 1'b1));
        end
        begin
            int b;
            b = 0;
            for (int o = 0; o < 10; o++) begin
                clear_row(b);
                connect(b, line_of(o, 1'b0));
                clear_row(b + cnt_tab[o] - 1);
                connect(b + cnt_tab[o] - 1, line_of(12 + o, 1'b0));
                b += cnt_tab[o];
            end
        end
        for (int o = 0; o < 10; o++) begin
            clear_row(120 + o);
            connect(120 + o, line_of(o, 1'b1));
            connect(120 + o, line_of(12 + o, 1'b1));
        end
        clear_row(130); connect(130, line_of(10, 1'b0)); connect(130, line_of(11, 1'b0));
        clear_row(131); connect(131, line_of(10, 1'b1));
        load_cfg();

        for (int k = 0; k < 10; k++) begin
            drive(12'h000 | (12'h1 << k), 10'h000, "R9 first term of block");
            drive(12'h000, 10'h000 | (10'h1 << k), "R9 last term of block");
        end
        drive(12'hC00, 10'h000, "R10 preset and clear");

        // R4: toggle serial data while idle
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            cfg_data = i[0] ^ i[2];
        end
        drive(12'h010, 10'h008, "R4 hold while idle");
        drive(12'h400, 10'h001, "R4 hold while idle");

        // R5: reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        tb_cfg = '0;
        drive(12'h000, 10'h000, "R5 reset clears config");

        @(negedge clk);
        #2;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule